// File: doc/BRIEF.md
# Two-Way Interleaved Flash Controller

This block returns 32-bit instruction words from two flash banks to a fetch unit. Each bank needs two core clocks for one access. Even word addresses go to one bank and odd word addresses go to the other. The controller overlaps the accesses of the two banks, so a run of sequential fetches completes at a rate of one word per clock. A request that breaks the run pays the full two-cycle access time. After that it is streaming again. A simple behavioural bank is built in, and each word of it holds a value computed from its word address, so tests can predict every word.

The requester presents a byte address, a valid bit and a sequential hint. It sees a ready bit and a registered response (data plus a one-cycle valid). Each time a request is accepted, the controller starts a speculative read of the following word in the idle bank. A request that matches that read is served one cycle after it is accepted. Any other request starts a fresh demand access, and the speculative result is dropped.

The sequencer has six states:
- **IDLE**: nothing has been accepted since reset.
- **WAIT**: the first cycle of a demand access. Ready is low, and at its exit edge the speculative read of the next word starts.
- **LAST**: an owed word completes at the next edge while a speculative read runs in the other bank.
- **SPEC**: only the speculative read is in flight. It completes at the next edge.
- **HELD**: the speculative word is parked in a buffer.
- **BUFHIT**: the owed word comes from that buffer while the next speculative read runs.

The transitions are:
- IDLE→WAIT, and LAST, SPEC, HELD or BUFHIT→WAIT, on a non-sequential acceptance.
- WAIT→LAST, always.
- LAST→LAST and BUFHIT→LAST on a hit.
- LAST→SPEC and BUFHIT→SPEC with no request.
- SPEC→BUFHIT and HELD→BUFHIT on a hit.
- SPEC→HELD with no request.
- HELD→HELD with no request.

Top module: `ilv_flash_ctl`

## Requirements
- R1: After reset, `resp_valid` is low and `req_ready` is high.
- R2: A non-sequential request accepted at clock edge E gives `resp_valid` high in the cycle that begins at edge E+2, and low in the cycle that begins at edge E+1 unless an earlier request owes that slot.
- R3: A sequential hit accepted at edge E gives its response in the cycle that begins at edge E+1. A hit has `req_seq`=1 and an address equal to the previously accepted address plus 4, computed modulo 2^ADDR_W so that it wraps.
- R4: Bank choice is byte-address bit 2. Back-to-back hits, which alternate between the banks, give one response every clock with no gap.
- R5: A request is treated as non-sequential, with R2 timing, if any of these holds: `req_seq`=1 but the address is not previous+4; `req_seq`=0 even though the address is previous+4; or it is the first request after reset.
- R6: `req_ready` is low for exactly the one cycle after a non-sequential acceptance, and high otherwise. A request presented while ready is low is ignored and produces no response.
- R7: Addresses are word-aligned byte addresses (bits 1:0 zero). The word at byte address A reads (w × 0x9E3779B1) XOR 0x5A5A5A5A, where w = A>>2, zero-extended and computed in 32-bit arithmetic.
- R8: Every accepted request produces exactly one response, valid for exactly one cycle, in acceptance order. No other responses appear.
- R9: A non-sequential request that arrives while a speculative read is in flight returns the data of its own address. This holds whether it targets the bank of the speculative read or the other bank.
- R10: A hit that arrives after one or more idle cycles, when the speculative word is already buffered or still in flight, is still served one cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Word-aligned byte address |
| req_seq | input | 1 | Requester's hint that this fetch follows the previous one |
| req_ready | output | 1 | Request is accepted at the next edge when valid |
| resp_valid | output | 1 | Response data valid, one cycle per accepted request |
| resp_data | output | 32 | Instruction word |

## Verification
The bench targets these corner cases:
- **Jump into a busy bank.** A jump whose target lies in the bank that holds a speculative read must restart that bank. A design that kept the speculative access would return the neighbouring word instead.
- **Misleading hints.** A sequential hint with the wrong address, and a correct address without the hint, must both take two cycles. A design that trusted the hint alone would answer one cycle early with the wrong word.
- **Idle gaps.** Gaps of one, two and five cycles before a hit exercise the buffered and still-in-flight speculation paths. Mishandling there shows up as a missing, late or duplicated response.
- **Address wrap.** A wrap from the top word to address zero, and a request offered during the not-ready bubble, must leave timing and response order unchanged.

// File: rtl/ilv_flash_pkg.sv
package ilv_flash_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_LAST,
        ST_SPEC,
        ST_HELD,
        ST_BUFHIT
    } ilv_state_e;

    // Content of the behavioural flash: a hash of the word address.
    function automatic logic [WORD_W-1:0] cell_word(input logic [31:0] w);
        return (w * 32'h9E37_79B1) ^ 32'h5A5A_5A5A;
    endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank
    import ilv_flash_pkg::*;
#(
    parameter int unsigned WADDR_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WADDR_W-1:0] waddr,
    output logic               done,
    output logic [WORD_W-1:0]  rdata
);

    // phase 1: first half of the access, phase 2: data ready
    logic [1:0]         phase;
    logic [WADDR_W-1:0] held_w;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase  <= 2'd0;
            held_w <= '0;
        end else if (start) begin
            phase  <= 2'd1;
            held_w <= waddr;
        end else if (phase == 2'd1) begin
            phase  <= 2'd2;
        end else begin
            phase  <= 2'd0;
        end
    end

    assign done  = (phase == 2'd2);
    assign rdata = cell_word(32'(held_w));

    AST_BANK_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done); // R4

    AST_BANK_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(start) && !start) |=> done); // R4

endmodule

// File: rtl/ilv_seq_ctl.sv
module ilv_seq_ctl
    import ilv_flash_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    localparam int unsigned WW    = ADDR_W - 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_seq,
    output logic                 req_ready,
    output logic                 resp_valid,
    output logic [WORD_W-1:0]    resp_data,
    output logic [1:0]           bank_start,
    output logic [1:0][WW-1:0]   bank_waddr,
    input  logic [1:0]           bank_done,
    input  logic [1:0][WORD_W-1:0] bank_rdata
);

    ilv_state_e        st, st_n;
    logic [WW-1:0]     spec_w, spec_n;     // word under speculation
    logic [WORD_W-1:0] pf_data;
    logic              pf_ld;
    logic              rv_n;
    logic [WORD_W-1:0] rd_n;
    logic [WW-1:0]     req_w, step_w;
    logic              spec_live, acc, hit, miss;

    assign req_w     = req_addr[ADDR_W-1:2];
    assign step_w    = spec_w + WW'(1);
    assign req_ready = (st != ST_WAIT);
    assign spec_live = (st == ST_LAST) || (st == ST_SPEC) ||
                       (st == ST_HELD) || (st == ST_BUFHIT);
    assign acc       = req_valid && req_ready;
    assign hit       = acc && req_seq && spec_live && (req_w == spec_w);
    assign miss      = acc && !hit;

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            spec_w     <= '0;
            pf_data    <= '0;
            resp_valid <= 1'b0;
            resp_data  <= '0;
        end else begin
            st         <= st_n;
            spec_w     <= spec_n;
            resp_valid <= rv_n;
            resp_data  <= rd_n;
            if (pf_ld) begin
                pf_data <= bank_rdata[spec_w[0]];
            end
        end
    end

    // next state, bank commands and response selection
    always_comb begin
        st_n       = st;
        spec_n     = spec_w;
        pf_ld      = 1'b0;
        rv_n       = 1'b0;
        rd_n       = resp_data;
        bank_start = '0;
        bank_waddr = '0;

        unique case (st)
            ST_IDLE:   ;
            ST_WAIT: begin
                bank_start[spec_w[0]] = 1'b1;
                bank_waddr[spec_w[0]] = spec_w;
                st_n = ST_LAST;
            end
            ST_LAST: begin
                rv_n = 1'b1;
                rd_n = bank_rdata[!spec_w[0]];
                st_n = ST_SPEC;
            end
            ST_SPEC: begin
                pf_ld = 1'b1;
                st_n  = ST_HELD;
            end
            ST_HELD:   ;
            ST_BUFHIT: begin
                rv_n = 1'b1;
                rd_n = pf_data;
                st_n = ST_SPEC;
            end
            default: st_n = ST_IDLE;
        endcase

        if (hit) begin
            bank_start[step_w[0]] = 1'b1;
            bank_waddr[step_w[0]] = step_w;
            spec_n = step_w;
            st_n   = (st == ST_LAST || st == ST_BUFHIT) ? ST_LAST : ST_BUFHIT;
        end else if (miss) begin
            bank_start[req_w[0]] = 1'b1;
            bank_waddr[req_w[0]] = req_w;
            spec_n = req_w + WW'(1);
            st_n   = ST_WAIT;
        end
    end

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_addr[1:0] == 2'b00)); // R7

    AST_READY_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        miss |=> !req_ready); // R6

    AST_READY_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |=> req_ready); // R6

    AST_MISS_TWO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> ##2 !resp_valid ##1 resp_valid); // R2

    AST_HIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ##2 resp_valid); // R3

    AST_OWED_WORD_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LAST) |-> bank_done[!spec_w[0]]); // R4

endmodule

// File: rtl/ilv_flash_ctl.sv
module ilv_flash_ctl
    import ilv_flash_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_seq,
    output logic              req_ready,
    output logic              resp_valid,
    output logic [WORD_W-1:0] resp_data
);

    localparam int unsigned WADDR_W = ADDR_W - 2;
    localparam int unsigned N_BANKS = 2;

    logic [N_BANKS-1:0]              bank_start;
    logic [N_BANKS-1:0][WADDR_W-1:0] bank_waddr;
    logic [N_BANKS-1:0]              bank_done;
    logic [N_BANKS-1:0][WORD_W-1:0]  bank_rdata;

    ilv_seq_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_seq    (req_seq),
        .req_ready  (req_ready),
        .resp_valid (resp_valid),
        .resp_data  (resp_data),
        .bank_start (bank_start),
        .bank_waddr (bank_waddr),
        .bank_done  (bank_done),
        .bank_rdata (bank_rdata)
    );

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        ilv_bank #(.WADDR_W(WADDR_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .start (bank_start[b]),
            .waddr (bank_waddr[b]),
            .done  (bank_done[b]),
            .rdata (bank_rdata[b])
        );
    end

endmodule

// File: tb/ilv_flash_ctl_test.sv
module ilv_flash_ctl_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW         = 16;
    localparam int QD         = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          req_seq = 1'b0;
    logic          req_ready;
    logic          resp_valid;
    logic [31:0]   resp_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit finished = 0;

    logic [31:0] q_data [QD];
    int          q_due  [QD];
    string       q_tag  [QD];
    string       q_lreq [QD];
    int          head = 0;
    int          tail = 0;

    bit            have_prev = 0;
    logic [AW-1:0] prev_addr = '0;
    bit            jumped = 0;
    string         scen = "";

    ilv_flash_ctl #(.ADDR_W(AW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_seq    (req_seq),
        .req_ready  (req_ready),
        .resp_valid (resp_valid),
        .resp_data  (resp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [31:0] exp_word(input logic [AW-1:0] a);
        logic [31:0] w;
        w = 32'(a >> 2);
        return (w * 32'h9E37_79B1) ^ 32'h5A5A_5A5A;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)",
                     req, what, act, exp, cyc);
        end
    endtask

    task automatic check_resp();
        int idx;
        if (resp_valid) begin
            if (head == tail) begin
                chk(1'b0, "R8", "unexpected response", resp_data, 32'h0);
            end else begin
                idx = head % QD;
                chk(resp_data == q_data[idx], {q_tag[idx], "/R7"}, "data",
                    resp_data, q_data[idx]);
                chk(cyc == q_due[idx], {q_lreq[idx], "/", q_tag[idx]},
                    "arrival cycle", 32'(cyc), 32'(q_due[idx]));
                head++;
            end
        end else if (head != tail && q_due[head % QD] <= cyc) begin
            chk(1'b0, "R8", "missing response", 32'(cyc), 32'(q_due[head % QD]));
            head++;
        end
    endtask

    task automatic accept(input logic [AW-1:0] a, input logic s);
        bit is_hit;
        int idx;
        is_hit = have_prev && s && (a == prev_addr + AW'(4));
        idx = tail % QD;
        q_data[idx] = exp_word(a);
        q_due[idx]  = cyc + 1 + (is_hit ? 1 : 2);
        q_lreq[idx] = is_hit ? "R3" : "R2";
        q_tag[idx]  = (scen != "") ? scen : (is_hit ? "R3" : "R2");
        tail++;
        have_prev = 1;
        prev_addr = a;
        jumped    = !is_hit;
    endtask

    task automatic step(input logic v, input logic [AW-1:0] a, input logic s);
        @(negedge clk);
        check_resp();
        chk(req_ready == !jumped, "R6", "ready", 32'(req_ready), 32'(!jumped));
        jumped    = 0;
        req_valid = v;
        req_addr  = a;
        req_seq   = s;
        if (v && req_ready) accept(a, s);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] ra;
        int r;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        chk(resp_valid == 1'b0, "R1", "resp_valid after reset", 32'(resp_valid), 32'h0);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'h1);

        // R5: first request after reset is non-sequential even with the hint
        scen = "R5";
        step(1'b1, 16'h0100, 1'b1);
        scen = "R2";
        idle(4);

        // R4 stream with R6 bubble request ignored
        scen = "R4";
        step(1'b1, 16'h0200, 1'b0);
        scen = "R6";
        step(1'b1, 16'h0204, 1'b1);
        scen = "R4";
        for (int i = 1; i <= 10; i++) step(1'b1, 16'h0200 + AW'(4 * i), 1'b1);

        // R10: hits after idle gaps
        scen = "R10";
        idle(1); step(1'b1, prev_addr + AW'(4), 1'b1);
        idle(2); step(1'b1, prev_addr + AW'(4), 1'b1);
        idle(5); step(1'b1, prev_addr + AW'(4), 1'b1);
        step(1'b1, prev_addr + AW'(4), 1'b1);

        // R5: misleading hints
        scen = "R5";
        step(1'b1, prev_addr + AW'(8), 1'b1);
        idle(1);
        step(1'b1, prev_addr + AW'(4), 1'b0);
        idle(1);

        // R9: mid-stream jumps into the speculating bank and the other bank
        scen = "R9";
        step(1'b1, prev_addr + AW'(4), 1'b1);
        step(1'b1, prev_addr + AW'(4), 1'b1);
        step(1'b1, prev_addr + AW'(16'h44), 1'b0);
        idle(1);
        step(1'b1, prev_addr + AW'(4), 1'b1);
        step(1'b1, prev_addr + AW'(16'h40), 1'b1);
        idle(1);
        step(1'b1, prev_addr + AW'(4), 1'b1);
        step(1'b1, prev_addr + AW'(4), 1'b1);

        // R3: address wrap
        scen = "R3";
        step(1'b1, 16'hFFF8, 1'b0);
        idle(1);
        step(1'b1, 16'hFFFC, 1'b1);
        step(1'b1, 16'h0000, 1'b1);
        step(1'b1, 16'h0004, 1'b1);
        idle(3);

        // constrained random mix
        for (int n = 0; n < 3000; n++) begin
            r = int'($urandom % 10);
            ra = AW'($urandom);
            ra[1:0] = 2'b00;
            scen = "";
            if (r < 2)       step(1'b0, '0, 1'b0);
            else if (r < 6)  step(1'b1, prev_addr + AW'(4), 1'b1);
            else if (r == 6) begin scen = "R5"; step(1'b1, prev_addr + AW'(8), 1'b1); end
            else if (r == 7) begin scen = "R5"; step(1'b1, prev_addr + AW'(4), 1'b0); end
            else             begin scen = "R9"; step(1'b1, ra, 1'($urandom)); end
        end

        scen = "";
        idle(6);
        chk(head == tail, "R8", "all responses delivered", 32'(tail - head), 32'h0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule